// File: doc/BRIEF.md
# Conduction Mode Selector with Debounce

This block picks, one switching cycle at a time, how a synchronous buck controller regulates. It chooses between fixed-frequency continuous-conduction PWM and variable-frequency hysteretic control, in which the low-side switch acts as an emulated diode. Once per switching cycle, at a strobe placed just before the high-side switch turns on, the block reads the sign of the low-side switch voltage. A positive sign means the load current is above the critical value. A negative sign means it is below.

A change of mode in either direction needs a run of consecutive samples that all point toward the other mode. A single disagreeing sample starts the run again from zero. Two conditions override the choice and keep the converter in continuous mode: an allow input held low, and a flag that marks a commanded output-voltage transition. In hysteretic mode the block drives the high-side request from the two hysteretic comparator outputs. It also blocks the low side after a current zero-cross until the next high-side pulse.

Top module: `cond_mode_sel`

## Requirements
- R1: After reset, `hyst_mode` is 0, `pwm_en` is 1, `de_en` is 0, `hs_req` is 0 and `ls_block` is 0.
- R2: While in continuous mode (`hyst_mode`=0), `hyst_mode` becomes 1 on the clock edge that captures the MATCH_N-th (default 8) consecutive strobed sample with `ls_sign_pos`=0. A strobed sample is one taken in a cycle with `cyc_stb`=1.
- R3: While in hysteretic mode, `hyst_mode` returns to 0 on the clock edge that captures the MATCH_N-th consecutive strobed sample with `ls_sign_pos`=1.
- R4: A strobed sample that agrees with the current mode clears the run, so a later mode change again needs MATCH_N consecutive disagreeing samples.
- R5: While `hyst_allow` is 0, the mode is continuous from the next clock edge on, and the run is cleared.
- R6: While `vtrans` is 1, the mode is continuous from the next clock edge on, and the run is cleared.
- R7: Cycles with `cyc_stb`=0 neither advance nor clear the run.
- R8: `pwm_en` equals the inverse of `hyst_mode`, and `de_en` equals `hyst_mode`.
- R9: In hysteretic mode, `hs_req` rises the cycle after `cmp_lo`=1 and falls the cycle after `cmp_hi`=1. `cmp_hi` wins when both are high, and otherwise `hs_req` holds. `hs_req` is never 1 outside hysteretic mode.
- R10: In hysteretic mode, `ls_block` rises the cycle after `zc_det`=1 when no high-side request is pending, and stays high until `hs_req` rises. It is 0 whenever `hs_req` is 1 or the mode is continuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_stb | input | 1 | One-cycle strobe just before high-side turn-on |
| ls_sign_pos | input | 1 | Sampled low-side voltage sign, 1 = above critical current |
| hyst_allow | input | 1 | 0 forces continuous mode |
| vtrans | input | 1 | 1 while an output-voltage transition is in progress |
| cmp_lo | input | 1 | Output is below the lower hysteretic threshold |
| cmp_hi | input | 1 | Output is above the upper hysteretic threshold |
| zc_det | input | 1 | Inductor current zero-cross detected |
| hyst_mode | output | 1 | 1 = hysteretic mode |
| pwm_en | output | 1 | Enables the PWM comparator and error-amplifier path |
| de_en | output | 1 | Diode-emulation enable for the low-side driver |
| hs_req | output | 1 | Hysteretic high-side gate request |
| ls_block | output | 1 | Low side held off after a zero-cross |

## Verification
Every cycle, the assertions check these properties:
- a mode change never happens without a strobe;
- every entry to hysteretic mode and every unforced exit from it is preceded by a full run of matching samples, counted independently in the checker;
- the allow input and the transition flag force continuous mode one cycle later;
- `hs_req` and `ls_block` appear only in hysteretic mode and are never high together.

Some properties only the scenarios can show. One is that the change lands exactly on the eighth sample and not the ninth. Another is that an agreeing sample at any position in the run restarts it. A third is that the run is cleared after a forced return. The exact cycle at which the comparators set and clear the gate request is also shown only by the scenarios.

// File: rtl/cond_mode_pkg.sv
package cond_mode_pkg;
    typedef enum logic {
        MODE_CCM  = 1'b0,
        MODE_HYST = 1'b1
    } cmode_e;
endpackage

// File: rtl/mode_debounce.sv
module mode_debounce #(
    parameter int MATCH_N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cyc_stb,
    input  logic                  ls_sign_pos,
    input  logic                  force_ccm,
    output cond_mode_pkg::cmode_e mode_d,
    output cond_mode_pkg::cmode_e mode_q
);
    import cond_mode_pkg::*;

    localparam int CNT_W = (MATCH_N > 2) ? $clog2(MATCH_N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MATCH_N - 1);

    typedef struct packed {
        cmode_e           mode;
        logic [CNT_W-1:0] cnt;
    } dbc_t;

    dbc_t st_d, st_q;
    logic disagree;

    always_comb begin
        st_d     = st_q;
        disagree = (st_q.mode == MODE_CCM) ? !ls_sign_pos : ls_sign_pos;
        if (force_ccm) begin
            st_d.mode = MODE_CCM;
            st_d.cnt  = '0;
        end else if (cyc_stb) begin
            if (!disagree) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == LAST) begin
                st_d.mode = (st_q.mode == MODE_CCM) ? MODE_HYST : MODE_CCM;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_CCM, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_d = st_d.mode;
    assign mode_q = st_q.mode;
endmodule

// File: rtl/hyst_gate.sv
module hyst_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic hyst_next,
    input  logic cmp_lo,
    input  logic cmp_hi,
    input  logic zc_det,
    output logic hs_req,
    output logic ls_block
);
    typedef struct packed {
        logic hs;
        logic blk;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!hyst_next) begin
            g_d.hs  = 1'b0;
            g_d.blk = 1'b0;
        end else begin
            if (cmp_hi) begin
                g_d.hs = 1'b0;
            end else if (cmp_lo) begin
                g_d.hs = 1'b1;
            end
            if (g_d.hs) begin
                g_d.blk = 1'b0;
            end else if (zc_det) begin
                g_d.blk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign hs_req   = g_q.hs;
    assign ls_block = g_q.blk;
endmodule

// File: rtl/cond_mode_sel.sv
module cond_mode_sel #(
    parameter int MATCH_N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    input  logic ls_sign_pos,
    input  logic hyst_allow,
    input  logic vtrans,
    input  logic cmp_lo,
    input  logic cmp_hi,
    input  logic zc_det,
    output logic hyst_mode,
    output logic pwm_en,
    output logic de_en,
    output logic hs_req,
    output logic ls_block
);
    import cond_mode_pkg::*;

    cmode_e mode_d, mode_q;
    logic   force_ccm;

    assign force_ccm = !hyst_allow || vtrans;

    mode_debounce #(.MATCH_N(MATCH_N)) i_dbc (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_stb     (cyc_stb),
        .ls_sign_pos (ls_sign_pos),
        .force_ccm   (force_ccm),
        .mode_d      (mode_d),
        .mode_q      (mode_q)
    );

    hyst_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .hyst_next (mode_d == MODE_HYST),
        .cmp_lo    (cmp_lo),
        .cmp_hi    (cmp_hi),
        .zc_det    (zc_det),
        .hs_req    (hs_req),
        .ls_block  (ls_block)
    );

    assign hyst_mode = (mode_q == MODE_HYST);
    assign pwm_en    = (mode_q == MODE_CCM);
    assign de_en     = (mode_q == MODE_HYST);
endmodule

// File: rtl/cond_mode_sel_chk.sv
module cond_mode_sel_chk #(
    parameter int MATCH_N = 8
) (
    input logic clk,
    input logic rst_n,
    input logic cyc_stb,
    input logic ls_sign_pos,
    input logic hyst_allow,
    input logic vtrans,
    input logic hyst_mode,
    input logic pwm_en,
    input logic de_en,
    input logic hs_req,
    input logic ls_block
);
    localparam int RUN_W = $clog2(MATCH_N + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MATCH_N);

    logic [RUN_W-1:0] neg_run, pos_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_run <= '0;
            pos_run <= '0;
        end else if (!hyst_allow || vtrans) begin
            neg_run <= '0;
            pos_run <= '0;
        end else if (cyc_stb) begin
            if (ls_sign_pos) begin
                neg_run <= '0;
                pos_run <= (pos_run == RUN_MAX) ? pos_run : pos_run + 1'b1;
            end else begin
                pos_run <= '0;
                neg_run <= (neg_run == RUN_MAX) ? neg_run : neg_run + 1'b1;
            end
        end
    end

    AST_ENTRY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hyst_mode) |-> (neg_run == RUN_MAX)); // R2

    AST_EXIT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hyst_mode) && $past(hyst_allow) && !$past(vtrans)) |-> (pos_run == RUN_MAX)); // R3

    AST_NO_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> !$rose(hyst_mode)); // R7

    AST_NO_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_stb && hyst_allow && !vtrans) |=> !$fell(hyst_mode)); // R7

    AST_ALLOW_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        !hyst_allow |=> !hyst_mode); // R5

    AST_VTRANS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        vtrans |=> !hyst_mode); // R6

    AST_PATH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en != hyst_mode) && (de_en == hyst_mode)); // R8

    AST_HS_IN_HYST: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req |-> hyst_mode); // R9

    AST_BLOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ls_block |-> (hyst_mode && !hs_req)); // R10
endmodule

bind cond_mode_sel cond_mode_sel_chk #(.MATCH_N(MATCH_N)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_stb     (cyc_stb),
    .ls_sign_pos (ls_sign_pos),
    .hyst_allow  (hyst_allow),
    .vtrans      (vtrans),
    .hyst_mode   (hyst_mode),
    .pwm_en      (pwm_en),
    .de_en       (de_en),
    .hs_req      (hs_req),
    .ls_block    (ls_block)
);

// File: tb/test_cond_mode_sel.sv
`timescale 1ns/1ps
module test_cond_mode_sel;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_stb = 1'b0, ls_sign_pos = 1'b1, hyst_allow = 1'b1, vtrans = 1'b0;
    logic cmp_lo = 1'b0, cmp_hi = 1'b0, zc_det = 1'b0;
    logic hyst_mode, pwm_en, de_en, hs_req, ls_block;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cond_mode_sel #(.MATCH_N(N)) i_cond_mode_sel (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ls_sign_pos(ls_sign_pos),
        .hyst_allow(hyst_allow), .vtrans(vtrans), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .zc_det(zc_det), .hyst_mode(hyst_mode), .pwm_en(pwm_en), .de_en(de_en),
        .hs_req(hs_req), .ls_block(ls_block)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cyc_stb = 1'b0; ls_sign_pos = 1'b1; hyst_allow = 1'b1;
        vtrans = 1'b0; cmp_lo = 1'b0; cmp_hi = 1'b0; zc_det = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic stb(input logic s);
        @(negedge clk);
        cyc_stb = 1'b1; ls_sign_pos = s;
        @(negedge clk);
        cyc_stb = 1'b0;
    endtask

    task automatic enter_hyst();
        for (int i = 0; i < N; i++) stb(1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 hyst_mode", hyst_mode, 1'b0);
        chk("R1 pwm_en", pwm_en, 1'b1);
        chk("R1 de_en", de_en, 1'b0);
        chk("R1 hs_req", hs_req, 1'b0);
        chk("R1 ls_block", ls_block, 1'b0);

        // R2 / R7: sweep run length with gaps between strobes
        for (int k = 1; k <= N + 2; k++) begin
            do_reset();
            for (int i = 0; i < k; i++) begin
                stb(1'b0);
                if (i == N - 2) chk("R2 not before run end", hyst_mode, 1'b0);
                idle(k % 3);
            end
            chk("R2/R7 entry after run", hyst_mode, (k >= N));
            chk("R8 pwm_en", pwm_en, !(k >= N));
            chk("R8 de_en", de_en, (k >= N));
        end

        // R3: exit sweep
        for (int j = 1; j <= N + 1; j++) begin
            do_reset();
            enter_hyst();
            for (int i = 0; i < j; i++) begin
                stb(1'b1);
                idle(j % 2);
            end
            chk("R3 exit after run", hyst_mode, !(j >= N));
        end

        // R4: agreeing sample at every position restarts the run
        for (int p = 0; p < N; p++) begin
            do_reset();
            for (int i = 0; i < p; i++) stb(1'b0);
            stb(1'b1);
            for (int i = 0; i < N - 1; i++) stb(1'b0);
            chk("R4 restarted run incomplete", hyst_mode, 1'b0);
            stb(1'b0);
            chk("R4 restarted run complete", hyst_mode, 1'b1);
        end
        for (int p = 0; p < N; p++) begin
            do_reset();
            enter_hyst();
            for (int i = 0; i < p; i++) stb(1'b1);
            stb(1'b0);
            for (int i = 0; i < N - 1; i++) stb(1'b1);
            chk("R4 exit run restarted", hyst_mode, 1'b1);
        end

        // R5: allow low forces continuous mode and clears the run
        do_reset();
        enter_hyst();
        @(negedge clk); hyst_allow = 1'b0;
        @(negedge clk);
        chk("R5 forced out", hyst_mode, 1'b0);
        hyst_allow = 1'b1;
        for (int i = 0; i < N - 1; i++) stb(1'b0);
        chk("R5 run cleared", hyst_mode, 1'b0);
        do_reset();
        for (int i = 0; i < 4; i++) stb(1'b0);
        @(negedge clk); hyst_allow = 1'b0;
        for (int i = 0; i < N + 2; i++) stb(1'b0);
        chk("R5 no entry while low", hyst_mode, 1'b0);
        @(negedge clk); hyst_allow = 1'b1;
        for (int i = 0; i < 4; i++) stb(1'b0);
        chk("R5 partial run discarded", hyst_mode, 1'b0);

        // R6: voltage transition forces continuous mode
        do_reset();
        enter_hyst();
        @(negedge clk); vtrans = 1'b1;
        @(negedge clk);
        chk("R6 forced out", hyst_mode, 1'b0);
        for (int i = 0; i < N + 1; i++) stb(1'b0);
        chk("R6 held during transition", hyst_mode, 1'b0);
        @(negedge clk); vtrans = 1'b0;
        for (int i = 0; i < N - 1; i++) stb(1'b0);
        chk("R6 run cleared", hyst_mode, 1'b0);
        stb(1'b0);
        chk("R6 entry after transition", hyst_mode, 1'b1);

        // R9 / R10: gate request and diode emulation
        do_reset();
        @(negedge clk); cmp_lo = 1'b1;
        @(negedge clk);
        chk("R9 no request in ccm", hs_req, 1'b0);
        cmp_lo = 1'b0; zc_det = 1'b1;
        @(negedge clk);
        chk("R10 no block in ccm", ls_block, 1'b0);
        zc_det = 1'b0;
        enter_hyst();
        @(negedge clk); cmp_lo = 1'b1;
        @(negedge clk); cmp_lo = 1'b0;
        chk("R9 set on lower", hs_req, 1'b1);
        idle(3);
        chk("R9 hold", hs_req, 1'b1);
        zc_det = 1'b1;
        @(negedge clk); zc_det = 1'b0;
        chk("R10 no block during pulse", ls_block, 1'b0);
        cmp_hi = 1'b1;
        @(negedge clk); cmp_hi = 1'b0;
        chk("R9 clear on upper", hs_req, 1'b0);
        zc_det = 1'b1;
        @(negedge clk); zc_det = 1'b0;
        chk("R10 block on zero-cross", ls_block, 1'b1);
        idle(2);
        chk("R10 block held", ls_block, 1'b1);
        cmp_lo = 1'b1; cmp_hi = 1'b1;
        @(negedge clk);
        chk("R9 upper wins", hs_req, 1'b0);
        cmp_hi = 1'b0;
        @(negedge clk); cmp_lo = 1'b0;
        chk("R9 set again", hs_req, 1'b1);
        chk("R10 block released by pulse", ls_block, 1'b0);
        @(negedge clk); hyst_allow = 1'b0;
        @(negedge clk); hyst_allow = 1'b1;
        chk("R9 request dropped on exit", hs_req, 1'b0);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule